// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits behind the command register of a byte-wide NOR flash array. It watches host write strobes, each with a latched address and data byte, and recognises the multi-write unlock sequences that select a device operation. When a sequence completes, it raises a one-cycle command pulse for the array controller. The pulse is one of read/reset, identifier mode, byte program (with the captured target address and byte), whole-array erase, or sector erase (with a mask of the sectors chosen). A write that breaks a sequence sends the decoder back to idle.

Sector erase uses a collection window. The first erase-confirm write opens the window. Each later confirm write adds one more sector and restarts a timer whose length is set in microseconds and clock megahertz. When the timer runs out with no further write, the accumulated erase is issued. A per-sector protection input blocks program and erase requests aimed at guarded sectors. While identifier mode is active, the block also drives the identifier readout byte for a read address.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in plain read mode (`mode_auto`=0). All command pulses are low, `win_open` is 0, `sect_mask` is 0, and `prog_addr`/`prog_data` are 0.
- R2: A sequence starts with byte AAh written to address 05555h, then byte 55h written to address 02AAAh. Address bit 15 is ignored in both matches, so 0D555h and 0AAAAh also match. All other address bits must match exactly.
- R3: After the two-write prefix, writing F0h to the key address 05555h pulses `cmd_reset` one cycle after that write and clears `mode_auto` in the same cycle.
- R4: After the prefix, writing 90h to the key address pulses `cmd_auto` one cycle after that write and sets `mode_auto`.
- R5: After the prefix, A0h to the key address arms a program. The next write, to any address, pulses `cmd_prog` one cycle later, with `prog_addr`/`prog_data` equal to that write's address and data.
- R6: The whole-array erase sequence is prefix, 80h to the key address, prefix, then 10h to the key address. It pulses `cmd_chip_erase` one cycle later, with `sect_mask` set to the bitwise inverse of `prot_mask`.
- R7: The sector erase sequence is prefix, 80h, prefix, then 30h to any address. Address bits 16..14 of that write select sector 0..7, which maps to `sect_mask` bit 0..7. The write opens the window (`win_open`=1 one cycle later) and sets only that sector's bit.
- R8: While the window is open, each 30h write sets another sector bit and restarts the timer. After WIN_US*CLK_MHZ consecutive cycles with no write, the next edge pulses `cmd_sect_erase` with the accumulated mask and closes the window.
- R9: While the window is open, any write whose data is not 30h closes the window with no erase pulse. It also clears `sect_mask` and returns the block to read mode.
- R10: Outside the window, a write that does not match the address and data expected at that point of a sequence returns the decoder to idle without a pulse, so a later key write is not accepted.
- R11: A program, or a first sector-erase confirm, aimed at a sector whose `prot_mask` bit is 1 produces no pulse. Inside the window, a confirm aimed at a protected sector sets no mask bit, although it still restarts the timer.
- R12: In identifier mode, `id_data` depends on `rd_addr` bits 1..0. The value 0 gives 01h, 1 gives 20h, 2 gives 01h if the sector in `rd_addr` bits 16..14 is protected and 00h if not, and 3 gives 00h. In read mode `id_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | 17 | Latched write address |
| wr_data | input | 8 | Latched write data |
| prot_mask | input | 8 | Per-sector protection flags |
| rd_addr | input | 17 | Read address for identifier readout |
| mode_auto | output | 1 | 1 = identifier mode, 0 = read mode |
| id_data | output | 8 | Identifier readout byte |
| cmd_reset | output | 1 | Read/reset command pulse |
| cmd_auto | output | 1 | Identifier mode command pulse |
| cmd_prog | output | 1 | Program command pulse |
| prog_addr | output | 17 | Captured program address |
| prog_data | output | 8 | Captured program byte |
| cmd_chip_erase | output | 1 | Whole-array erase pulse |
| cmd_sect_erase | output | 1 | Sector erase pulse |
| sect_mask | output | 8 | Sectors selected for erase |
| win_open | output | 1 | Sector-erase collection window open |

## Verification
Some properties hold on every cycle, and the bound checker tests those. At most one command pulse fires at a time. A program pulse carries the previous cycle's write. A non-30h write in the window closes it and restores read mode. An issued sector mask never touches a protected sector. The identifier byte is zero outside identifier mode. Other behaviour can only be shown by the bench's write sequences against its cycle model. That covers recognising the unlock prefix with bit 15 flipped, the timer restart, and the exact expiry cycle. It also covers dropping a broken prefix, and the sector-dependent identifier readout.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG,
      ST_ERS1, ST_ERS2, ST_ERS3, ST_WIN
   } seq_state_t;

   localparam logic [7:0] KEY_BYTE_A = 8'hAA;
   localparam logic [7:0] KEY_BYTE_B = 8'h55;
   localparam logic [7:0] OP_RESET   = 8'hF0;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_PROGRAM = 8'hA0;
   localparam logic [7:0] OP_ERASE   = 8'h80;
   localparam logic [7:0] OP_CHIP    = 8'h10;
   localparam logic [7:0] OP_SECTOR  = 8'h30;
   localparam logic [7:0] ID_VENDOR  = 8'h01;
   localparam logic [7:0] ID_PART    = 8'h20;
   localparam int unsigned KEY_ADDR_A = 32'h05555;
   localparam int unsigned KEY_ADDR_B = 32'h02AAA;
   localparam int unsigned IGNORE_BIT = 15;
endpackage

// File: rtl/fcs_win_timer.sv
module fcs_win_timer #(
   parameter int unsigned WIN_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam int unsigned CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

   generate
      if (WIN_CYC == 1) begin : g_single
         logic unused_tmr;
         assign unused_tmr = clk ^ rst_n;
         assign expired = run && !load;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (load)                 cnt_q <= CNT_W'(WIN_CYC - 1);
            else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end
         assign expired = run && !load && (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/fcs_id_mux.sv
module fcs_id_mux import flash_cmd_pkg::*; #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned SECT_W = 3
) (
   input  logic                     mode_auto,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [(1<<SECT_W)-1:0]   prot_mask,
   output logic [7:0]               id_data
);
   logic [SECT_W-1:0] rd_sect;
   logic unused_rd;
   assign rd_sect   = rd_addr[ADDR_W-1 -: SECT_W];
   assign unused_rd = ^rd_addr[ADDR_W-SECT_W-1:2];

   always_comb begin
      id_data = 8'h00;
      if (mode_auto) begin
         case (rd_addr[1:0])
            2'd0:    id_data = ID_VENDOR;
            2'd1:    id_data = ID_PART;
            2'd2:    id_data = {7'b0, prot_mask[rd_sect]};
            default: id_data = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm import flash_cmd_pkg::*; #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned SECT_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [7:0]               wr_data,
   input  logic [(1<<SECT_W)-1:0]   prot_mask,
   input  logic                     tmr_expired,
   output logic                     tmr_load,
   output logic                     tmr_run,
   output logic                     mode_auto,
   output logic                     cmd_reset,
   output logic                     cmd_auto,
   output logic                     cmd_prog,
   output logic [ADDR_W-1:0]        prog_addr,
   output logic [7:0]               prog_data,
   output logic                     cmd_chip_erase,
   output logic                     cmd_sect_erase,
   output logic [(1<<SECT_W)-1:0]   sect_mask,
   output logic                     win_open
);
   localparam int unsigned NSECT = 1 << SECT_W;
   localparam logic [ADDR_W-1:0] DC_MASK = ADDR_W'(1) << IGNORE_BIT;
   localparam logic [ADDR_W-1:0] ADDR_A  = ADDR_W'(KEY_ADDR_A);
   localparam logic [ADDR_W-1:0] ADDR_B  = ADDR_W'(KEY_ADDR_B);

   seq_state_t        st_q;
   logic [SECT_W-1:0] wr_sect;
   logic              sect_locked, at_a, at_b, key_a, key_b;

   assign wr_sect     = wr_addr[ADDR_W-1 -: SECT_W];
   assign sect_locked = prot_mask[wr_sect];
   assign at_a        = (wr_addr & ~DC_MASK) == ADDR_A;
   assign at_b        = (wr_addr & ~DC_MASK) == ADDR_B;
   assign key_a       = at_a && (wr_data == KEY_BYTE_A);
   assign key_b       = at_b && (wr_data == KEY_BYTE_B);

   assign tmr_run  = (st_q == ST_WIN);
   assign win_open = tmr_run;
   assign tmr_load = wr_en && (wr_data == OP_SECTOR) &&
                     ((st_q == ST_WIN) || (st_q == ST_ERS3 && !sect_locked));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q           <= ST_IDLE;
         mode_auto      <= 1'b0;
         cmd_reset      <= 1'b0;
         cmd_auto       <= 1'b0;
         cmd_prog       <= 1'b0;
         cmd_chip_erase <= 1'b0;
         cmd_sect_erase <= 1'b0;
         prog_addr      <= '0;
         prog_data      <= '0;
         sect_mask      <= '0;
      end else begin
         cmd_reset      <= 1'b0;
         cmd_auto       <= 1'b0;
         cmd_prog       <= 1'b0;
         cmd_chip_erase <= 1'b0;
         cmd_sect_erase <= 1'b0;
         if (st_q == ST_WIN) begin
            if (wr_en) begin
               if (wr_data == OP_SECTOR) begin
                  if (!sect_locked) sect_mask[wr_sect] <= 1'b1;
               end else begin
                  st_q      <= ST_IDLE;
                  sect_mask <= '0;
                  mode_auto <= 1'b0;
               end
            end else if (tmr_expired) begin
               cmd_sect_erase <= 1'b1;
               st_q           <= ST_IDLE;
            end
         end else if (wr_en) begin
            st_q <= ST_IDLE;
            unique case (st_q)
               ST_IDLE: if (key_a) st_q <= ST_UNL1;
               ST_UNL1: if (key_b) st_q <= ST_UNL2;
               ST_UNL2: if (at_a) begin
                  case (wr_data)
                     OP_RESET:   begin cmd_reset <= 1'b1; mode_auto <= 1'b0; end
                     OP_IDENT:   begin cmd_auto  <= 1'b1; mode_auto <= 1'b1; end
                     OP_PROGRAM: st_q <= ST_PROG;
                     OP_ERASE:   st_q <= ST_ERS1;
                     default:    st_q <= ST_IDLE;
                  endcase
               end
               ST_PROG: if (!sect_locked) begin
                  cmd_prog  <= 1'b1;
                  prog_addr <= wr_addr;
                  prog_data <= wr_data;
               end
               ST_ERS1: if (key_a) st_q <= ST_ERS2;
               ST_ERS2: if (key_b) st_q <= ST_ERS3;
               ST_ERS3: begin
                  if (at_a && wr_data == OP_CHIP) begin
                     cmd_chip_erase <= 1'b1;
                     sect_mask      <= ~prot_mask;
                  end else if (wr_data == OP_SECTOR && !sect_locked) begin
                     sect_mask          <= '0;
                     sect_mask[wr_sect] <= 1'b1;
                     st_q               <= ST_WIN;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   logic unused_n;
   assign unused_n = (NSECT == 0);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
   parameter int unsigned ADDR_W  = 17,
   parameter int unsigned SECT_W  = 3,
   parameter int unsigned WIN_US  = 80,
   parameter int unsigned CLK_MHZ = 125
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [7:0]               wr_data,
   input  logic [(1<<SECT_W)-1:0]   prot_mask,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic                     mode_auto,
   output logic [7:0]               id_data,
   output logic                     cmd_reset,
   output logic                     cmd_auto,
   output logic                     cmd_prog,
   output logic [ADDR_W-1:0]        prog_addr,
   output logic [7:0]               prog_data,
   output logic                     cmd_chip_erase,
   output logic                     cmd_sect_erase,
   output logic [(1<<SECT_W)-1:0]   sect_mask,
   output logic                     win_open
);
   localparam int unsigned WIN_CYC = WIN_US * CLK_MHZ;

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ADDR_W must cover the key addresses");
      end
      if (SECT_W < 1 || SECT_W + 2 > ADDR_W) begin : g_bad_sect
         $error("SECT_W out of range for ADDR_W");
      end
      if (WIN_CYC < 1) begin : g_bad_win
         $error("window must last at least one cycle");
      end
   endgenerate

   logic tmr_load, tmr_run, tmr_expired;

   fcs_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .prot_mask(prot_mask), .tmr_expired(tmr_expired),
      .tmr_load(tmr_load), .tmr_run(tmr_run), .mode_auto(mode_auto),
      .cmd_reset(cmd_reset), .cmd_auto(cmd_auto), .cmd_prog(cmd_prog),
      .prog_addr(prog_addr), .prog_data(prog_data),
      .cmd_chip_erase(cmd_chip_erase), .cmd_sect_erase(cmd_sect_erase),
      .sect_mask(sect_mask), .win_open(win_open)
   );

   fcs_win_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
      .expired(tmr_expired)
   );

   fcs_id_mux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_id (
      .mode_auto(mode_auto), .rd_addr(rd_addr), .prot_mask(prot_mask),
      .id_data(id_data)
   );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned SECT_W = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [7:0]               wr_data,
   input logic [(1<<SECT_W)-1:0]   prot_mask,
   input logic [ADDR_W-1:0]        rd_addr,
   input logic                     mode_auto,
   input logic [7:0]               id_data,
   input logic                     cmd_reset,
   input logic                     cmd_auto,
   input logic                     cmd_prog,
   input logic [ADDR_W-1:0]        prog_addr,
   input logic [7:0]               prog_data,
   input logic                     cmd_chip_erase,
   input logic                     cmd_sect_erase,
   input logic [(1<<SECT_W)-1:0]   sect_mask,
   input logic                     win_open
);
   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_reset, cmd_auto, cmd_prog, cmd_chip_erase, cmd_sect_erase})); // R10
   AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_reset || cmd_auto || cmd_prog || cmd_chip_erase) |-> $past(wr_en)); // R2
   AST_RESET_READ: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |-> !mode_auto); // R3
   AST_AUTO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_auto |-> mode_auto); // R4
   AST_PROG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_prog |-> (prog_addr == $past(wr_addr)) && (prog_data == $past(wr_data))); // R5
   AST_PROG_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_prog |-> !$past(prot_mask[wr_addr[ADDR_W-1 -: SECT_W]])); // R11
   AST_CHIP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_chip_erase |-> sect_mask == ~$past(prot_mask)); // R6
   AST_SECT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_sect_erase |-> $past(win_open) && !win_open && (sect_mask != '0)); // R8
   AST_SECT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_sect_erase |-> (sect_mask & prot_mask) == '0); // R11
   AST_WIN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && wr_en && wr_data != 8'h30) |=>
      (!win_open && !mode_auto && sect_mask == '0 && !cmd_sect_erase)); // R9
   AST_ID_READMODE: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_auto |-> id_data == 8'h00); // R12
   AST_ID_VENDOR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_auto && rd_addr[1:0] == 2'd0) |-> id_data == 8'h01); // R12
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (.*);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
   localparam int WIN_US = 2, CLK_MHZ = 4, WIN_CYC = WIN_US * CLK_MHZ;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [16:0] wr_addr = '0, rd_addr = '0;
   logic [7:0]  wr_data = '0, prot_mask = 8'b0000_0100;
   logic        mode_auto, cmd_reset, cmd_auto, cmd_prog, cmd_chip_erase, cmd_sect_erase, win_open;
   logic [7:0]  id_data, prog_data, sect_mask;
   logic [16:0] prog_addr;

   always #4 clk = ~clk;

   flash_cmd_seq #(.ADDR_W(17), .SECT_W(3), .WIN_US(WIN_US), .CLK_MHZ(CLK_MHZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .prot_mask(prot_mask), .rd_addr(rd_addr), .mode_auto(mode_auto), .id_data(id_data),
      .cmd_reset(cmd_reset), .cmd_auto(cmd_auto), .cmd_prog(cmd_prog),
      .prog_addr(prog_addr), .prog_data(prog_data), .cmd_chip_erase(cmd_chip_erase),
      .cmd_sect_erase(cmd_sect_erase), .sect_mask(sect_mask), .win_open(win_open));

   int checks = 0, failures = 0;
   logic [24:0] hist[$];
   logic e_auto, e_rst, e_id, e_prog, e_chip, e_sect, m_win;
   logic [7:0]  e_mask, e_pdata;
   logic [16:0] e_paddr;
   int m_tmr;

   function automatic bit is_k1(logic [16:0] a); return (a & ~17'h08000) == 17'h05555; endfunction
   function automatic bit is_k2(logic [16:0] a); return (a & ~17'h08000) == 17'h02AAA; endfunction
   function automatic int sec(logic [16:0] a); return int'(a[16:14]); endfunction

   function automatic logic [7:0] exp_id();
      if (!e_auto) return 8'h00;
      case (rd_addr[1:0])
         2'd0: return 8'h01;
         2'd1: return 8'h20;
         2'd2: return {7'b0, prot_mask[sec(rd_addr)]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic mdl_reset();
      hist.delete(); e_auto = 0; e_rst = 0; e_id = 0; e_prog = 0; e_chip = 0; e_sect = 0;
      m_win = 0; e_mask = 0; e_pdata = 0; e_paddr = 0; m_tmr = 0;
   endtask

   task automatic mdl_edge(bit we, logic [16:0] a, logic [7:0] d);
      e_rst = 0; e_id = 0; e_prog = 0; e_chip = 0; e_sect = 0;
      if (m_win) begin
         if (we) begin
            if (d == 8'h30) begin
               if (!prot_mask[sec(a)]) e_mask[sec(a)] = 1'b1;
               m_tmr = WIN_CYC - 1;
            end else begin
               m_win = 0; e_mask = 0; e_auto = 0;
            end
         end else if (m_tmr == 0) begin
            e_sect = 1; m_win = 0;
         end else m_tmr--;
      end else if (we) begin
         bit keep = 0;
         hist.push_back({a, d});
         case (hist.size())
            1: keep = is_k1(a) && d == 8'hAA;
            2: keep = is_k2(a) && d == 8'h55;
            3: if (is_k1(a)) begin
                  if (d == 8'hF0) begin e_rst = 1; e_auto = 0; end
                  if (d == 8'h90) begin e_id = 1; e_auto = 1; end
                  keep = (d == 8'hA0) || (d == 8'h80);
               end
            4: if (hist[2][7:0] == 8'hA0) begin
                  if (!prot_mask[sec(a)]) begin e_prog = 1; e_paddr = a; e_pdata = d; end
               end else keep = is_k1(a) && d == 8'hAA;
            5: keep = is_k2(a) && d == 8'h55;
            6: if (is_k1(a) && d == 8'h10) begin
                  e_chip = 1; e_mask = ~prot_mask;
               end else if (d == 8'h30 && !prot_mask[sec(a)]) begin
                  e_mask = 0; e_mask[sec(a)] = 1'b1; m_win = 1; m_tmr = WIN_CYC - 1;
               end
            default: keep = 0;
         endcase
         if (!keep) hist.delete();
      end
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare(string req);
      chk(req, "mode_auto", 32'(mode_auto), 32'(e_auto));
      chk(req, "cmd_reset", 32'(cmd_reset), 32'(e_rst));
      chk(req, "cmd_auto", 32'(cmd_auto), 32'(e_id));
      chk(req, "cmd_prog", 32'(cmd_prog), 32'(e_prog));
      chk(req, "prog_addr", 32'(prog_addr), 32'(e_paddr));
      chk(req, "prog_data", 32'(prog_data), 32'(e_pdata));
      chk(req, "cmd_chip_erase", 32'(cmd_chip_erase), 32'(e_chip));
      chk(req, "cmd_sect_erase", 32'(cmd_sect_erase), 32'(e_sect));
      chk(req, "sect_mask", 32'(sect_mask), 32'(e_mask));
      chk(req, "win_open", 32'(win_open), 32'(m_win));
      chk(req, "id_data", 32'(id_data), 32'(exp_id()));
   endtask

   task automatic step(bit we, logic [16:0] a, logic [7:0] d, string req);
      wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      mdl_edge(we, a, d);
      @(negedge clk);
      wr_en = 1'b0;
      compare(req);
   endtask

   task automatic wr(logic [16:0] a, logic [7:0] d, string req); step(1, a, d, req); endtask
   task automatic idle(int n, string req); for (int i = 0; i < n; i++) step(0, '0, '0, req); endtask
   task automatic unlock(string req); wr(17'h05555, 8'hAA, req); wr(17'h02AAA, 8'h55, req); endtask
   task automatic erase_head(string req);
      unlock(req); wr(17'h05555, 8'h80, req); unlock(req);
   endtask
   task automatic rd(logic [16:0] a, string req); rd_addr = a; #1; compare(req); endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      mdl_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
      idle(2, "R1");
      // R4 / R12: identifier mode and readout
      unlock("R2"); wr(17'h05555, 8'h90, "R4"); idle(1, "R4");
      rd(17'h00000, "R12"); rd(17'h00001, "R12");
      rd(17'h0A002, "R12"); rd(17'h04002, "R12"); rd(17'h00003, "R12");
      // R2 / R3: prefix with bit 15 set, then read/reset
      wr(17'h0D555, 8'hAA, "R2"); wr(17'h0AAAA, 8'h55, "R2"); wr(17'h0D555, 8'hF0, "R3");
      rd(17'h00001, "R12");
      // R5: program an unprotected byte, R11: protected one ignored
      unlock("R5"); wr(17'h05555, 8'hA0, "R5"); wr(17'h13456, 8'h5A, "R5"); idle(1, "R5");
      unlock("R11"); wr(17'h05555, 8'hA0, "R11"); wr(17'h09000, 8'h33, "R11"); idle(1, "R11");
      // R6: whole-array erase
      erase_head("R6"); wr(17'h05555, 8'h10, "R6"); idle(1, "R6");
      // R7 / R8: single sector, full expiry
      erase_head("R7"); wr(17'h1C010, 8'h30, "R7"); idle(WIN_CYC + 2, "R8");
      // R8 / R11: accumulate with restarts, protected sector not added
      erase_head("R8"); wr(17'h04000, 8'h30, "R8"); idle(WIN_CYC - 3, "R8");
      wr(17'h10000, 8'h30, "R8"); idle(WIN_CYC - 2, "R8");
      wr(17'h08123, 8'h30, "R11"); idle(WIN_CYC + 2, "R8");
      // R11: first confirm to protected sector opens nothing
      erase_head("R11"); wr(17'h0B000, 8'h30, "R11"); idle(2, "R11");
      // R9: abort from identifier mode
      unlock("R4"); wr(17'h05555, 8'h90, "R4");
      erase_head("R9"); wr(17'h00100, 8'h30, "R9"); idle(2, "R9");
      wr(17'h00100, 8'h00, "R9"); idle(WIN_CYC + 2, "R9");
      // R10: broken prefix, then stray key writes
      wr(17'h05555, 8'hAA, "R10"); wr(17'h02AAA, 8'h56, "R10"); wr(17'h05555, 8'h90, "R10");
      wr(17'h05555, 8'hAA, "R10"); wr(17'h12AAA, 8'h55, "R10"); wr(17'h05555, 8'h90, "R10");
      unlock("R10"); wr(17'h05555, 8'h77, "R10"); wr(17'h05555, 8'hA0, "R10");
      wr(17'h00001, 8'h01, "R10"); idle(2, "R10");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule